// File: doc/BRIEF.md
# Interrupt Cause and Mask Group

This block is a single group of an I/O interrupt controller. It holds one bit for each of 32 interrupt sources. Incoming event pulses are collected in a sticky cause register. A mask register decides which latched causes may raise the group interrupt request. A third register, the abort mask, decides which latched causes drive a request that aborts the associated DMA engine. A plain control word is also held. It is stored and read back, and it has no effect on masking.

Software reaches the registers through a simple bus with address, write enable, write data, read enable and read data. Several addresses let software change single bits with one write and no read-modify-write:

- A cause write clears the bits written as zero.
- A cause-set write raises the bits written as one, so software can trigger a source itself.
- A mask-clear write unmasks the bits written as zero.

The per-bit pending vector (cause and not mask) goes out to a moderation stage that is placed after this block.

Top module: `irq_cause_group`

## Requirements
- R1: After reset the cause register, abort mask and control word read 0. The mask reads all ones. `irq_o`, `abort_o` and `pend_o` are low.
- R2: A 1 on any bit of `evt_i` for one cycle sets that cause bit at the next clock edge. The bit stays set until software clears it.
- R3: A write to the cause address (0) clears each cause bit written as 0. A cause bit written as 1 keeps its value.
- R4: A write to the cause-set address (1) sets each cause bit written as 1. Bits written as 0 are left unchanged. A read of address 1 returns the cause register.
- R5: A write to the mask address (2) loads the mask directly, and a mask bit of 1 blocks that source. A read of address 2 or 3 returns the current mask.
- R6: A write to the mask-clear address (3) clears each mask bit written as 0. Mask bits written as 1 are unchanged.
- R7: When an event and a cause clear hit the same bit in the same cycle, the event wins and the bit ends up set.
- R8: `pend_o` equals cause AND NOT mask, taken from the current register values. A read of address 6 returns it. `irq_o` is the OR of `pend_o`, registered, so it lags `pend_o` by one clock cycle.
- R9: The abort mask (address 4) is loaded directly and can be read back. `abort_o` is the OR of cause AND abort mask, taken from the current register values.
- R10: The control word (address 5) is loaded directly and can be read back. Writing it leaves the mask unchanged, so all sources stay masked until software unmasks them.
- R11: A read of address 7 returns 0. `rd_data` is 0 while `rd_en` is low. Writes to addresses 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per source |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational, 0 when not reading |
| pend_o | output | 32 | Unmasked pending causes, to the moderation stage |
| irq_o | output | 1 | Registered group interrupt request |
| abort_o | output | 1 | DMA abort request |

## Verification
A write or event presented before a rising edge is visible on the register contents, on `pend_o`, on `abort_o` and on read data right after that edge. `irq_o` follows one edge later.

The bench drives its inputs on falling edges and samples on the next falling edge. It checks `pend_o` and `abort_o` first. It then confirms that `irq_o` has not yet moved, and checks `irq_o` again one falling edge later. Every source bit is swept through each of these paths in turn.

// File: rtl/irq_cause_group.sv
module irq_cause_group #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_i,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  pend_o,
  output logic          irq_o,
  output logic          abort_o
);

  localparam logic [AW-1:0] A_CAUSE = AW'(0);
  localparam logic [AW-1:0] A_CSET  = AW'(1);
  localparam logic [AW-1:0] A_MASK  = AW'(2);
  localparam logic [AW-1:0] A_MCLR  = AW'(3);
  localparam logic [AW-1:0] A_AMASK = AW'(4);
  localparam logic [AW-1:0] A_CTRL  = AW'(5);
  localparam logic [AW-1:0] A_PEND  = AW'(6);
  localparam logic [W-1:0]  ONES    = '1;

  logic [W-1:0] cause_q, mask_q, amask_q, ctrl_q;
  logic [W-1:0] cause_keep, cause_raise, mask_keep;

  wire wr_cause = wr_en && (addr == A_CAUSE);
  wire wr_cset  = wr_en && (addr == A_CSET);
  wire wr_mask  = wr_en && (addr == A_MASK);
  wire wr_mclr  = wr_en && (addr == A_MCLR);
  wire wr_amask = wr_en && (addr == A_AMASK);
  wire wr_ctrl  = wr_en && (addr == A_CTRL);

  assign cause_keep  = wr_cause ? wr_data : ONES;
  assign cause_raise = (wr_cset ? wr_data : '0) | evt_i;
  assign mask_keep   = wr_mclr ? wr_data : ONES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= ONES;
      amask_q <= '0;
      ctrl_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      cause_q <= (cause_q & cause_keep) | cause_raise;
      mask_q  <= wr_mask ? wr_data : (mask_q & mask_keep);
      if (wr_amask) amask_q <= wr_data;
      if (wr_ctrl)  ctrl_q  <= wr_data;
      irq_o   <= |pend_o;
    end
  end

  assign pend_o  = cause_q & ~mask_q;
  assign abort_o = |(cause_q & amask_q);

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_CAUSE, A_CSET: rd_data = cause_q;
        A_MASK, A_MCLR:  rd_data = mask_q;
        A_AMASK:         rd_data = amask_q;
        A_CTRL:          rd_data = ctrl_q;
        A_PEND:          rd_data = pend_o;
        default:         rd_data = '0;
      endcase
    end
  end

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

  // R3
  cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause && evt_i == '0) |=> ((cause_q & ~$past(wr_data)) == '0));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wr_data)));

  // R6
  mclr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> (((mask_q ^ $past(mask_q)) & $past(wr_data)) == '0));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mask || wr_mclr) |=> $stable(mask_q));

  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == '0) |=> !irq_o);

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amask_q == '0) |-> !abort_o);

endmodule

// File: tb/tb_irq_cause_group.sv
`timescale 1ns/1ps
module tb_irq_cause_group;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt_i;
  logic [2:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic [31:0] pend_o;
  logic        irq_o;
  logic        abort_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_cause_group dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pend_o(pend_o),
    .irq_o(irq_o), .abort_o(abort_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    #0.5;
    check(tag, rd_data, exp);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [31:0] e);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; evt_i = e;
    @(negedge clk);
    wr_en = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rdchk(3'd0, 32'h0, "R1 cause");
    rdchk(3'd2, 32'hFFFF_FFFF, "R1 mask");
    rdchk(3'd4, 32'h0, "R1 amask");
    rdchk(3'd5, 32'h0, "R1 ctrl");
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 abort", {31'b0, abort_o}, 32'h0);
    check("R1 pend", pend_o, 32'h0);

    for (int i = 0; i < 32; i++) begin
      automatic logic [31:0] b = 32'h1 << i;
      automatic logic [31:0] nb = 32'h1 << ((i + 1) % 32);
      // R2 event latches and sticks
      pulse(b);
      rdchk(3'd0, b, "R2 cause latch");
      @(negedge clk);
      rdchk(3'd1, b, "R4 cause read via set addr");
      // R5 masked source raises nothing
      check("R5 pend masked", pend_o, 32'h0);
      check("R5 irq masked", {31'b0, irq_o}, 32'h0);
      // R6 mask-clear
      wr(3'd3, ~b, '0);
      rdchk(3'd3, ~b, "R6 mask after clear");
      check("R8 pend same cycle", pend_o, b);
      rdchk(3'd6, b, "R8 pend read");
      check("R8 irq not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      check("R8 irq one cycle later", {31'b0, irq_o}, 32'h1);
      wr(3'd3, 32'hFFFF_FFFF, '0);
      rdchk(3'd2, ~b, "R6 ones leave mask");
      // R3 clear semantics
      wr(3'd0, 32'hFFFF_FFFF, '0);
      rdchk(3'd0, b, "R3 ones keep cause");
      wr(3'd0, ~b, '0);
      rdchk(3'd0, 32'h0, "R3 zero clears cause");
      check("R8 pend cleared", pend_o, 32'h0);
      @(negedge clk);
      check("R8 irq drops", {31'b0, irq_o}, 32'h0);
      // R4 set address
      wr(3'd1, b, '0);
      rdchk(3'd0, b, "R4 set raises bit");
      // R9 abort path
      wr(3'd4, b, '0);
      rdchk(3'd4, b, "R9 amask read");
      check("R9 abort on", {31'b0, abort_o}, 32'h1);
      wr(3'd4, nb, '0);
      check("R9 abort off", {31'b0, abort_o}, 32'h0);
      wr(3'd0, 32'h0, '0);
      wr(3'd2, 32'hFFFF_FFFF, '0);
      wr(3'd4, 32'h0, '0);
      rdchk(3'd0, 32'h0, "R3 cleanup cause");
    end

    // R7 event beats clear in same cycle
    wr(3'd1, 32'h0000_00F0, '0);
    wr(3'd0, 32'h0, 32'h0000_0018);
    rdchk(3'd0, 32'h0000_0018, "R7 event wins over clear");
    wr(3'd0, 32'h0, '0);

    // R5 direct mask load
    wr(3'd1, 32'hFFFF_FFFF, '0);
    wr(3'd2, 32'h0000_FFFF, '0);
    rdchk(3'd2, 32'h0000_FFFF, "R5 mask load");
    check("R8 pend pattern", pend_o, 32'hFFFF_0000);
    wr(3'd2, 32'hFFFF_FFFF, '0);
    wr(3'd0, 32'h0, '0);

    // R10 control word does not unmask
    wr(3'd5, 32'hA5A5_0003, '0);
    rdchk(3'd5, 32'hA5A5_0003, "R10 ctrl read");
    rdchk(3'd2, 32'hFFFF_FFFF, "R10 mask still all ones");

    // R11 unmapped and idle reads, ignored writes
    wr(3'd7, 32'h1234_5678, '0);
    wr(3'd6, 32'hFFFF_FFFF, '0);
    rdchk(3'd7, 32'h0, "R11 unmapped read");
    rdchk(3'd2, 32'hFFFF_FFFF, "R11 mask untouched");
    rdchk(3'd0, 32'h0, "R11 cause untouched");
    rdchk(3'd5, 32'hA5A5_0003, "R11 ctrl untouched");
    addr = 3'd5; rd_en = 1'b0;
    #0.5;
    check("R11 idle rd_data", rd_data, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule